// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the operand fields of a 32-bit load/store machine into the value the datapath needs next. A three-bit mode code selects how the unit resolves the operand. It can pass a register value through, deliver a literal, add a signed byte displacement to a base register, step the program counter by a signed word offset, or build an absolute jump target from the instruction field and the top bits of the next PC.

The unit is purely combinational. The decoder drives the mode code and the operand fields. The register file supplies the base value and the fetch stage supplies the current PC. In the same cycle the unit returns a 32-bit result and a flag that is high only when that result is a memory address. The flag lets the load/store or fetch path ignore results that are plain operand values.

Top module: `eag_unit`

## Requirements
- R1: The mode code `am_sel` is decoded as 0 = register, 1 = immediate, 2 = base-displacement, 3 = PC-relative, 4 = pseudo-direct; codes 5, 6 and 7 are invalid.
- R2: In register mode `ea_value` equals `base_val` and `ea_is_mem` is 0.
- R3: In immediate mode `ea_value` is the 16-bit `ofs_field` sign-extended to 32 bits, and `ea_is_mem` is 0.
- R4: In base-displacement mode `ea_value` is `base_val` plus the sign-extended `ofs_field` taken as bytes, so a zero field yields `base_val` and a field of 4 yields the next word. `ea_is_mem` is 1.
- R5: In PC-relative mode `ea_value` is (`pc_now` + 4) plus the sign-extended `ofs_field` shifted left by 2, so negative fields reach backward. `ea_is_mem` is 1.
- R6: In pseudo-direct mode `ea_value` is {(`pc_now`+4)[31:28], `tgt_field`[25:0], 2'b00} and `ea_is_mem` is 1.
- R7: For an invalid mode code `ea_value` is 0 and `ea_is_mem` is 0.
- R8: All additions wrap modulo 2^32, with no saturation and no error indication.
- R9: The outputs follow the inputs combinationally, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| am_sel | input | 3 | Addressing mode code |
| base_val | input | 32 | Base register contents |
| ofs_field | input | 16 | Literal, byte displacement or word branch offset |
| pc_now | input | 32 | Address of the current instruction |
| tgt_field | input | 26 | Jump target field of the instruction |
| ea_value | output | 32 | Resolved address or operand value |
| ea_is_mem | output | 1 | High when ea_value is a memory address |

## Verification
Immediate assertions in the top module re-check every evaluation. They confirm that register mode passes the base through, that the low 16 bits of a base-displacement sum agree with a narrow add, that PC-relative results keep the PC's byte alignment, that jump targets carry the next PC's upper nibble and two zero bits, and that the flag and zero output follow the mode code. The full 32-bit values need the bench's reference functions, run over random vectors and directed cases. These cover the sign extension of negative fields, backward branches, wraparound past the top of the address space and a PC whose increment carries into the upper nibble.

// File: rtl/eag_pkg.sv
// Package: shared widths and mode codes for the effective address unit.
// Assumes a byte-addressed machine with 4-byte words.
package eag_pkg;
    localparam int ADDR_W     = 32;
    localparam int OFS_W      = 16;
    localparam int TGT_W      = 26;
    localparam int WORD_SHIFT = 2;

    typedef enum logic [2:0] {
        AM_REG   = 3'd0,
        AM_IMM   = 3'd1,
        AM_BASE  = 3'd2,
        AM_PCREL = 3'd3,
        AM_JUMP  = 3'd4
    } am_mode_e;
endpackage

// File: rtl/eag_sext.sv
// Module: sign extender. Widens IN_W bits to OUT_W bits by copying the top bit.
// Assumes OUT_W > IN_W.
module eag_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);
    localparam int EXT_W = OUT_W - IN_W;

    // Replicate the sign bit above the field.
    always_comb begin
        wide = {{EXT_W{narrow[IN_W-1]}}, narrow};
    end
endmodule

// File: rtl/eag_adder.sv
// Module: W-bit wrapping adder. Assumes the carry out is discarded (modulo 2^W).
module eag_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] sum
);
    // Plain modular addition.
    always_comb begin
        sum = lhs + rhs;
    end
endmodule

// File: rtl/eag_jump.sv
// Module: pseudo-direct target builder. Splices the upper bits of the next PC
// above a word-index target field and appends SHIFT zero bits.
// Assumes ADDR_W > TGT_W + SHIFT.
module eag_jump #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [TGT_W-1:0]  tgt,
    output logic [ADDR_W-1:0] jump_addr
);
    localparam int LOW_W = TGT_W + SHIFT;
    localparam int UP_W  = ADDR_W - LOW_W;

    // Concatenate region bits, target and alignment zeros.
    always_comb begin
        jump_addr = {pc_next[ADDR_W-1:LOW_W], tgt, {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/eag_unit.sv
// Module: effective address generation unit (top). Resolves five addressing
// modes in one combinational pass and flags results that are memory addresses.
// Assumes the mode code is decoded as in eag_pkg; unknown codes give zero.
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int OW    = OFS_W,
    parameter int TW    = TGT_W,
    parameter int SHIFT = WORD_SHIFT
) (
    input  logic [2:0]    am_sel,
    input  logic [AW-1:0] base_val,
    input  logic [OW-1:0] ofs_field,
    input  logic [AW-1:0] pc_now,
    input  logic [TW-1:0] tgt_field,
    output logic [AW-1:0] ea_value,
    output logic          ea_is_mem
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(1) << SHIFT;
    localparam int            LOW_W      = TW + SHIFT;

    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] ofs_words;
    logic [AW-1:0] pc_next;
    logic [AW-1:0] base_sum;
    logic [AW-1:0] rel_sum;
    logic [AW-1:0] jump_addr;

    eag_sext #(.IN_W(OW), .OUT_W(AW)) u_sext (
        .narrow (ofs_field),
        .wide   (ofs_ext)
    );

    // Scale the sign-extended offset from words to bytes.
    always_comb begin
        ofs_words = ofs_ext << SHIFT;
    end

    eag_adder #(.W(AW)) u_pc_step (
        .lhs (pc_now),
        .rhs (WORD_BYTES),
        .sum (pc_next)
    );

    eag_adder #(.W(AW)) u_base_add (
        .lhs (base_val),
        .rhs (ofs_ext),
        .sum (base_sum)
    );

    eag_adder #(.W(AW)) u_rel_add (
        .lhs (pc_next),
        .rhs (ofs_words),
        .sum (rel_sum)
    );

    eag_jump #(.ADDR_W(AW), .TGT_W(TW), .SHIFT(SHIFT)) u_jump (
        .pc_next   (pc_next),
        .tgt       (tgt_field),
        .jump_addr (jump_addr)
    );

    // Select the result and the memory-address flag by mode code.
    always_comb begin
        ea_value  = '0;
        ea_is_mem = 1'b0;
        case (am_sel)
            AM_REG:   ea_value = base_val;
            AM_IMM:   ea_value = ofs_ext;
            AM_BASE:  begin ea_value = base_sum;  ea_is_mem = 1'b1; end
            AM_PCREL: begin ea_value = rel_sum;   ea_is_mem = 1'b1; end
            AM_JUMP:  begin ea_value = jump_addr; ea_is_mem = 1'b1; end
            default:  begin ea_value = '0;        ea_is_mem = 1'b0; end
        endcase
    end

    // Cross-check the selected result against its inputs on every evaluation.
    always_comb begin
        if (!$isunknown({am_sel, base_val, ofs_field, pc_now, tgt_field})) begin
            if (am_sel == AM_REG)
                assert_reg_pass_R2: assert (ea_value == base_val && !ea_is_mem);
            if (am_sel == AM_BASE)
                assert_base_low_R4: assert (ea_value[OW-1:0] == OW'(base_val[OW-1:0] + ofs_field));
            if (am_sel == AM_PCREL)
                assert_rel_align_R5: assert (ea_value[SHIFT-1:0] == pc_now[SHIFT-1:0]);
            if (am_sel == AM_JUMP)
                assert_jump_shape_R6: assert (ea_value[LOW_W-1:SHIFT] == tgt_field
                                              && ea_value[SHIFT-1:0] == '0);
            if (am_sel > AM_JUMP)
                assert_invalid_zero_R7: assert (ea_value == '0 && !ea_is_mem);
            assert_flag_decode_R1: assert (ea_is_mem == (am_sel inside {AM_BASE, AM_PCREL, AM_JUMP}));
        end
    end
endmodule

// File: tb/eag_unit_test.sv
// Bench: random vectors from a fixed seed plus directed corners, compared
// with reference functions written from the requirements.
module eag_unit_test;
    logic        clk = 1'b0;
    logic [2:0]  am_sel = '0;
    logic [31:0] base_val = '0;
    logic [15:0] ofs_field = '0;
    logic [31:0] pc_now = '0;
    logic [25:0] tgt_field = '0;
    logic [31:0] ea_value;
    logic        ea_is_mem;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    eag_unit uut (
        .am_sel    (am_sel),
        .base_val  (base_val),
        .ofs_field (ofs_field),
        .pc_now    (pc_now),
        .tgt_field (tgt_field),
        .ea_value  (ea_value),
        .ea_is_mem (ea_is_mem)
    );

    function automatic logic [31:0] ref_val(input logic [2:0] m, input logic [31:0] b,
                                            input logic [15:0] o, input logic [31:0] p,
                                            input logic [25:0] t);
        logic [31:0] s;
        logic [31:0] pn;
        s  = {{16{o[15]}}, o};
        pn = p + 32'd4;
        case (m)
            3'd0: return b;
            3'd1: return s;
            3'd2: return b + s;
            3'd3: return pn + (s * 32'd4);
            3'd4: return {pn[31:28], t, 2'b00};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic ref_mem(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd3) || (m == 3'd4);
    endfunction

    task automatic apply(input string req, input logic [2:0] m, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] p, input logic [25:0] t);
        logic [31:0] ev;
        logic        ef;
        @(posedge clk);
        am_sel = m; base_val = b; ofs_field = o; pc_now = p; tgt_field = t;
        ev = ref_val(m, b, o, p, t);
        ef = ref_mem(m);
        @(negedge clk);
        n_checks++;
        if (ea_value !== ev || ea_is_mem !== ef) begin
            n_fails++;
            $display("FAIL %s mode=%0d value=%h/flag=%b expected %h/%b",
                     req, m, ea_value, ea_is_mem, ev, ef);
        end
    endtask

    initial begin
        void'($urandom(32'd7741));
        // Idle state: register mode with zero inputs
        apply("R2", 3'd0, 32'h0, 16'h0, 32'h0, 26'h0);
        apply("R2", 3'd0, 32'hDEAD_BEEF, 16'h8000, 32'h1000, 26'h3FF_FFFF);
        apply("R3", 3'd1, 32'h1234, 16'h7FFF, 32'h0, 26'h0);
        apply("R3", 3'd1, 32'h1234, 16'hFFFE, 32'h0, 26'h0);
        apply("R4", 3'd2, 32'h1000_0040, 16'h0000, 32'h0, 26'h0);
        apply("R4", 3'd2, 32'h1000_0040, 16'h0004, 32'h0, 26'h0);
        apply("R4", 3'd2, 32'h1000_0040, 16'hFFF0, 32'h0, 26'h0);
        apply("R5", 3'd3, 32'h0, 16'h0010, 32'h0040_0100, 26'h0);
        apply("R5", 3'd3, 32'h0, 16'hFFFF, 32'h0040_0100, 26'h0);
        apply("R5", 3'd3, 32'h0, 16'h8000, 32'h0040_0100, 26'h0);
        apply("R6", 3'd4, 32'h0, 16'h0, 32'h0040_0000, 26'h010_0002);
        apply("R6", 3'd4, 32'h0, 16'h0, 32'h0FFF_FFFC, 26'h3FF_FFFF);
        apply("R7", 3'd5, 32'hFFFF_FFFF, 16'hFFFF, 32'hFFFF_FFFF, 26'h3FF_FFFF);
        apply("R7", 3'd6, 32'h1, 16'h1, 32'h1, 26'h1);
        apply("R7", 3'd7, 32'h8000_0000, 16'h4, 32'h4, 26'h4);
        apply("R8", 3'd2, 32'hFFFF_FFFC, 16'h0008, 32'h0, 26'h0);
        apply("R8", 3'd3, 32'h0, 16'hFFFE, 32'h0000_0000, 26'h0);
        apply("R8", 3'd3, 32'h0, 16'h0001, 32'hFFFF_FFFC, 26'h0);
        // R1 and R9: every code with random fields, checked in the same cycle
        for (int i = 0; i < 3000; i++) begin
            apply("R1/R9", 3'($urandom_range(0, 7)), $urandom, 16'($urandom),
                  $urandom, 26'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule